// File: doc/BRIEF.md
# Chip-Select Wait-State Timing Generator

This block paces external memory accesses for a small set of memory banks. Each bank has its own option set: a wait count for a single access or the first beat of a burst, a smaller wait count for the later burst beats, a relaxed-timing bit that doubles both waits, an extended-read-hold bit, and a selector that hands beat termination to an external acknowledge input. The options are loaded through a simple write port and take effect for accesses accepted afterwards.

A requester presents a bank number, a read/write flag and a burst flag. The block accepts the request when it is not busy and then emits a one-clock transfer-acknowledge strobe in the last clock of each beat. A burst is four beats long. If the previous access was a read from a bank with extended hold, and the next request is a write or targets another bank, one idle clock is inserted first and flagged on a dedicated output.

Top module: `cs_wait_timer`

## Requirements
- R1: A single access, or the first beat of a burst, lasts 2 + W clocks, where W is the bank's 4-bit first-beat wait (0 to 15). The acknowledge strobe is high for exactly one clock, the last clock of the beat, which is the (2 + W)-th clock after the accepting edge.
- R2: A burst has four beats. Each beat after the first lasts 1 + B clocks, where B is the wait decoded from the bank's 3-bit burst code (codes 0 to 3 give 0 to 3 waits). Busy falls in the clock after the last acknowledge.
- R3: With the bank's relaxed-timing bit set, both W and B are doubled before use.
- R4: A burst code with its top bit set (4 to 7) is treated as 3 waits, and the error output pulses for one clock, the first clock of the access, when a burst starts on such a bank with internal timing. Single accesses never raise it.
- R5: With external acknowledge selected, both wait fields are ignored; the beat ends, and the strobe is high, in the clock in which the external acknowledge input is high.
- R6: After a read from a bank with extended hold, a following write, or a read to a different bank, is preceded by one clock with the idle output high and busy low, and is accepted one clock later than it otherwise would be. A read to the same bank, or any request after a bank without extended hold, gets no idle clock.
- R7: A request is accepted only at an edge where busy is low; requests raised and dropped while busy is high are ignored.
- R8: After reset, busy, strobe, idle and error outputs are low; bank 0 has first-beat wait 15 with relaxed timing (a 32-clock single access); banks 1 to 3 have all fields cleared (a 2-clock single access).
- R9: A configuration write replaces the addressed bank's options for all accesses accepted after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for bank options |
| cfg_bank | input | 2 | Bank addressed by the write |
| cfg_first_wait | input | 4 | First-beat wait count |
| cfg_burst_code | input | 3 | Later-beat wait code |
| cfg_relax | input | 1 | Relaxed timing (double waits) |
| cfg_ehold | input | 1 | Extended hold after reads |
| cfg_ext_ack | input | 1 | Beats end on external acknowledge |
| req_valid | input | 1 | Access request |
| req_bank | input | 2 | Target bank |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = four-beat burst |
| ext_ack | input | 1 | External acknowledge |
| beat_ack | output | 1 | One-clock strobe in last clock of a beat |
| busy | output | 1 | Access in progress |
| idle_ins | output | 1 | Inserted idle clock |
| cfg_err | output | 1 | Reserved burst code used |

## Verification
Busy and the error pulse are registered at the accepting edge, so they are due in the first sampled clock after it; the strobe is due in the (2 + W)-th sampled clock and then every (1 + B) clocks, while the idle flag is due one clock after the conflicting request and shifts everything else by one. The bench samples at the falling edge and counts clocks from the accepting edge, checking the strobe at every clock of the access so both early and late strobes are caught. In external mode the strobe follows the acknowledge input within the same clock, so it is checked shortly after that input changes.

// File: rtl/cs_wait_pkg.sv
`timescale 1ns/1ps
// Shared widths, option record and wait-count arithmetic for the
// wait-state timing generator. Assumes burst codes with the top bit
// set are reserved and clamp to the largest legal code.
package cs_wait_pkg;
    localparam int FW_W  = 4;            // first-beat wait width
    localparam int BW_W  = 3;            // burst-beat code width
    localparam int CNT_W = FW_W + 2;     // holds 1 + 2*max first wait

    typedef struct packed {
        logic [FW_W-1:0] first_wait;
        logic [BW_W-1:0] burst_code;
        logic            relax;
        logic            ehold;
        logic            ext_ack;
    } bank_opt_t;

    // Counter load for the first beat: beat length minus one.
    function automatic logic [CNT_W-1:0] first_load(input bank_opt_t o);
        logic [CNT_W-1:0] w;
        w = CNT_W'(o.first_wait);
        if (o.relax) w = w << 1;
        return w + CNT_W'(1);
    endfunction

    // Counter load for later beats: decoded wait, doubled if relaxed.
    function automatic logic [CNT_W-1:0] burst_load(input bank_opt_t o);
        logic [CNT_W-1:0] w;
        w = o.burst_code[BW_W-1] ? CNT_W'(3) : CNT_W'(o.burst_code[BW_W-2:0]);
        if (o.relax) w = w << 1;
        return w;
    endfunction
endpackage

// File: rtl/cs_bank_opts.sv
`timescale 1ns/1ps
// Per-bank option storage with a write port and one read port.
// Assumes NUM_BANKS is a power of two so every index is populated.
module cs_bank_opts
    import cs_wait_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BANK_W-1:0] wr_bank,
    input  bank_opt_t         wr_opt,
    input  logic [BANK_W-1:0] rd_bank,
    output bank_opt_t         rd_opt
);
    bank_opt_t opts_q [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam bank_opt_t RST_OPT = (g == 0) ?
            '{first_wait: '1, burst_code: '0, relax: 1'b1, ehold: 1'b0, ext_ack: 1'b0} :
            '{first_wait: '0, burst_code: '0, relax: 1'b0, ehold: 1'b0, ext_ack: 1'b0};

        // Hold one bank's options; load defaults on reset, new value on write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                opts_q[g] <= RST_OPT;
            else if (wr && wr_bank == BANK_W'(g))
                opts_q[g] <= wr_opt;
        end
    end

    // Select the options of the requested bank.
    assign rd_opt = opts_q[rd_bank];
endmodule

// File: rtl/cs_beat_timer.sv
`timescale 1ns/1ps
// Counts the clocks of each beat of an access and strobes the
// acknowledge in a beat's last clock. Assumes start only arrives
// while idle; in external mode the input acknowledge ends each beat.
module cs_beat_timer
    import cs_wait_pkg::*;
#(
    parameter int BURST_BEATS = 4,
    localparam int BL_W       = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             burst,
    input  logic             ext_mode,
    input  logic [CNT_W-1:0] first_ld,
    input  logic [CNT_W-1:0] burst_ld,
    input  logic             ext_ack,
    output logic             busy,
    output logic             beat_ack,
    output logic             done
);
    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;
    logic [BL_W-1:0]  left_q;
    logic             ext_q;
    logic             beat_end;

    // A beat ends on the external strobe or when the count runs out.
    assign beat_end = busy_q && (ext_q ? ext_ack : (cnt_q == '0));

    // Sequence beats: load on start, reload per beat, count down between.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            cnt_q    <= '0;
            reload_q <= '0;
            left_q   <= '0;
            ext_q    <= 1'b0;
        end else if (start) begin
            busy_q   <= 1'b1;
            cnt_q    <= first_ld;
            reload_q <= burst_ld;
            left_q   <= burst ? BL_W'(BURST_BEATS - 1) : '0;
            ext_q    <= ext_mode;
        end else if (beat_end) begin
            if (left_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                left_q <= left_q - 1'b1;
                cnt_q  <= reload_q;
            end
        end else if (busy_q && !ext_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy     = busy_q;
    assign beat_ack = beat_end;
    assign done     = beat_end && (left_q == '0);

    a_r1_ack_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        beat_ack |-> busy);
    a_r2_holds_until_last: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    a_r5_ext_waits_input: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ext_q && !ext_ack) |-> !beat_ack);
    a_r1_count_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ext_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/cs_hold_tracker.sv
`timescale 1ns/1ps
// Decides acceptance and inserts one idle clock after a held read
// when the next request is a write or targets another bank.
// Assumes the requester keeps its request up until busy rises.
module cs_hold_tracker #(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic              req_write,
    input  logic              req_ehold,
    input  logic              busy,
    input  logic              done,
    output logic              start,
    output logic              idle_ins
);
    logic              pend_q;
    logic [BANK_W-1:0] pend_bank_q;
    logic [BANK_W-1:0] cur_bank_q;
    logic              cur_hold_q;
    logic              idle_q;
    logic              conflict;
    logic              gap;

    // A pending hold blocks writes and reads to other banks for one clock.
    assign conflict = pend_q && (req_write || req_bank != pend_bank_q);
    assign start    = req_valid && !busy && !conflict;
    assign gap      = req_valid && !busy && conflict;

    // Track the running access and the hold it leaves behind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_bank_q <= '0;
            cur_bank_q  <= '0;
            cur_hold_q  <= 1'b0;
            idle_q      <= 1'b0;
        end else begin
            idle_q <= gap;
            if (start) begin
                cur_bank_q <= req_bank;
                cur_hold_q <= req_ehold && !req_write;
            end
            if (gap || start) begin
                pend_q <= 1'b0;
            end else if (done && cur_hold_q) begin
                pend_q      <= 1'b1;
                pend_bank_q <= cur_bank_q;
            end
        end
    end

    assign idle_ins = idle_q;

    a_r6_idle_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        idle_ins |=> !idle_ins);
    a_r6_idle_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        idle_ins |-> !busy);
    a_r7_start_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/cs_wait_timer.sv
`timescale 1ns/1ps
// Top of the wait-state timing generator: option storage, acceptance
// with idle insertion, and the beat timer. Options are sampled at the
// accepting edge; later writes do not affect an access in flight.
module cs_wait_timer
    import cs_wait_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int BURST_BEATS = 4,
    localparam int BANK_W     = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [BANK_W-1:0] cfg_bank,
    input  logic [FW_W-1:0]   cfg_first_wait,
    input  logic [BW_W-1:0]   cfg_burst_code,
    input  logic              cfg_relax,
    input  logic              cfg_ehold,
    input  logic              cfg_ext_ack,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic              req_write,
    input  logic              req_burst,
    input  logic              ext_ack,
    output logic              beat_ack,
    output logic              busy,
    output logic              idle_ins,
    output logic              cfg_err
);
    bank_opt_t wr_opt;
    bank_opt_t req_opt;
    logic      start;
    logic      done;
    logic      err_q;

    // Pack the configuration inputs into one option record.
    always_comb begin
        wr_opt.first_wait = cfg_first_wait;
        wr_opt.burst_code = cfg_burst_code;
        wr_opt.relax      = cfg_relax;
        wr_opt.ehold      = cfg_ehold;
        wr_opt.ext_ack    = cfg_ext_ack;
    end

    cs_bank_opts #(.NUM_BANKS(NUM_BANKS)) u_opts (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .wr_bank (cfg_bank),
        .wr_opt  (wr_opt),
        .rd_bank (req_bank),
        .rd_opt  (req_opt)
    );

    cs_hold_tracker #(.BANK_W(BANK_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_bank  (req_bank),
        .req_write (req_write),
        .req_ehold (req_opt.ehold),
        .busy      (busy),
        .done      (done),
        .start     (start),
        .idle_ins  (idle_ins)
    );

    cs_beat_timer #(.BURST_BEATS(BURST_BEATS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .burst    (req_burst),
        .ext_mode (req_opt.ext_ack),
        .first_ld (first_load(req_opt)),
        .burst_ld (burst_load(req_opt)),
        .ext_ack  (ext_ack),
        .busy     (busy),
        .beat_ack (beat_ack),
        .done     (done)
    );

    // Flag a burst that starts on a bank holding a reserved burst code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else
            err_q <= start && req_burst && !req_opt.ext_ack
                     && req_opt.burst_code[BW_W-1];
    end

    assign cfg_err = err_q;

    a_r4_err_first_clock: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (busy && !$past(busy)));
    a_r6_no_start_in_idle_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_ins && req_valid) |-> !busy);
endmodule

// File: tb/cs_wait_timer_test.sv
`timescale 1ns/1ps
module cs_wait_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_bank = '0;
    logic [3:0] cfg_first_wait = '0;
    logic [2:0] cfg_burst_code = '0;
    logic       cfg_relax = 1'b0, cfg_ehold = 1'b0, cfg_ext_ack = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_bank = '0;
    logic       req_write = 1'b0, req_burst = 1'b0, ext_ack = 1'b0;
    logic       beat_ack, busy, idle_ins, cfg_err;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cs_wait_timer uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_bank(cfg_bank),
        .cfg_first_wait(cfg_first_wait), .cfg_burst_code(cfg_burst_code),
        .cfg_relax(cfg_relax), .cfg_ehold(cfg_ehold), .cfg_ext_ack(cfg_ext_ack),
        .req_valid(req_valid), .req_bank(req_bank), .req_write(req_write),
        .req_burst(req_burst), .ext_ack(ext_ack), .beat_ack(beat_ack),
        .busy(busy), .idle_ins(idle_ins), .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic [1:0] bank;
        logic [3:0] fw;
        logic [2:0] bw;
        logic       relax;
        logic       wr;
        logic       burst;
        logic [5:0] l1;
        logic [3:0] lb;
        logic       err;
    } vec_t;

    // Expected first-beat and later-beat lengths worked out from R1 to R4.
    localparam vec_t VECS [0:7] = '{
        '{2'd1, 4'd0,  3'd0, 1'b0, 1'b0, 1'b0, 6'd2,  4'd1, 1'b0},
        '{2'd2, 4'd5,  3'd0, 1'b0, 1'b1, 1'b0, 6'd7,  4'd1, 1'b0},
        '{2'd3, 4'd2,  3'd1, 1'b0, 1'b0, 1'b1, 6'd4,  4'd2, 1'b0},
        '{2'd1, 4'd3,  3'd2, 1'b1, 1'b1, 1'b1, 6'd8,  4'd5, 1'b0},
        '{2'd2, 4'd15, 3'd3, 1'b1, 1'b0, 1'b1, 6'd32, 4'd7, 1'b0},
        '{2'd3, 4'd1,  3'd5, 1'b0, 1'b0, 1'b1, 6'd3,  4'd4, 1'b1},
        '{2'd1, 4'd0,  3'd7, 1'b1, 1'b1, 1'b1, 6'd2,  4'd7, 1'b1},
        '{2'd2, 4'd4,  3'd6, 1'b0, 1'b0, 1'b0, 6'd6,  4'd1, 1'b0}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] b, input logic [3:0] fw, input logic [2:0] bw,
                           input logic rx, input logic eh, input logic ex);
        cfg_bank = b; cfg_first_wait = fw; cfg_burst_code = bw;
        cfg_relax = rx; cfg_ehold = eh; cfg_ext_ack = ex; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Issue one access and check idle, busy, error and every strobe clock.
    task automatic do_access(input logic [1:0] b, input logic wr, input logic bu,
                             input logic gap, input int l1, input int lb,
                             input logic exp_err, input string req);
        int last;
        int bad;
        req_bank = b; req_write = wr; req_burst = bu; req_valid = 1'b1;
        @(negedge clk);
        if (gap) begin
            check(idle_ins === 1'b1 && busy === 1'b0, "R6", "idle clock {idle,busy}",
                  {idle_ins, busy}, 2);
            @(negedge clk);
        end else begin
            check(idle_ins === 1'b0, "R6", "no idle clock", idle_ins, 0);
        end
        req_valid = 1'b0;
        check(busy === 1'b1, req, "busy after accept", busy, 1);
        check(cfg_err === exp_err, "R4", "error pulse", cfg_err, exp_err);
        last = bu ? l1 + 3 * lb : l1;
        bad = -1;
        for (int n = 1; n <= last; n++) begin
            logic exp_ack;
            if (n > 1) @(negedge clk);
            exp_ack = (n == l1) || (bu && n > l1 && ((n - l1) % lb) == 0);
            if (beat_ack !== exp_ack && bad < 0) bad = n;
        end
        check(bad < 0, req, "strobe timing (first wrong clock)", bad, -1);
        @(negedge clk);
        check(busy === 1'b0 && beat_ack === 1'b0, "R2", "free after last beat",
              {busy, beat_ack}, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy === 0 && beat_ack === 0 && idle_ins === 0 && cfg_err === 0,
              "R8", "outputs in reset", {busy, beat_ack, idle_ins, cfg_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 0 && beat_ack === 0 && idle_ins === 0 && cfg_err === 0,
              "R8", "outputs after reset", {busy, beat_ack, idle_ins, cfg_err}, 0);

        // R8: default bank timings
        do_access(2'd0, 1'b0, 1'b0, 1'b0, 32, 1, 1'b0, "R8");
        do_access(2'd3, 1'b1, 1'b0, 1'b0, 2, 1, 1'b0, "R8");

        // R1 R2 R3 R4 R9: table of configurations and accesses
        for (int i = 0; i < 8; i++) begin
            set_cfg(VECS[i].bank, VECS[i].fw, VECS[i].bw, VECS[i].relax, 1'b0, 1'b0);
            do_access(VECS[i].bank, VECS[i].wr, VECS[i].burst, 1'b0,
                      int'(VECS[i].l1), int'(VECS[i].lb), VECS[i].err,
                      VECS[i].burst ? (VECS[i].relax ? "R3" : "R2") : "R1");
        end

        // R6: extended hold after reads
        set_cfg(2'd1, 4'd0, 3'd0, 1'b0, 1'b1, 1'b0);
        set_cfg(2'd2, 4'd0, 3'd0, 1'b0, 1'b0, 1'b0);
        do_access(2'd1, 1'b0, 1'b0, 1'b0, 2, 1, 1'b0, "R6");
        do_access(2'd1, 1'b1, 1'b0, 1'b1, 2, 1, 1'b0, "R6");
        do_access(2'd1, 1'b0, 1'b0, 1'b0, 2, 1, 1'b0, "R6");
        do_access(2'd1, 1'b0, 1'b0, 1'b0, 2, 1, 1'b0, "R6");
        do_access(2'd2, 1'b0, 1'b0, 1'b1, 2, 1, 1'b0, "R6");
        do_access(2'd2, 1'b1, 1'b0, 1'b0, 2, 1, 1'b0, "R6");

        // R5: external acknowledge ignores the wait fields
        set_cfg(2'd3, 4'd15, 3'd3, 1'b1, 1'b0, 1'b1);
        req_bank = 2'd3; req_write = 1'b0; req_burst = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        begin
            int early = 0;
            for (int n = 0; n < 6; n++) begin
                if (beat_ack !== 1'b0 || busy !== 1'b1) early++;
                @(negedge clk);
            end
            check(early == 0, "R5", "no strobe before external ack", early, 0);
        end
        ext_ack = 1'b1;
        #1;
        check(beat_ack === 1'b1, "R5", "strobe with external ack", beat_ack, 1);
        @(negedge clk);
        ext_ack = 1'b0;
        check(busy === 1'b0, "R5", "free after external ack", busy, 0);

        // R7: requests while busy are ignored
        set_cfg(2'd1, 4'd10, 3'd0, 1'b0, 1'b0, 1'b0);
        req_bank = 2'd1; req_write = 1'b0; req_burst = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        begin
            int bad = -1;
            for (int n = 1; n <= 12; n++) begin
                if (n > 1) @(negedge clk);
                if (n == 3) begin req_bank = 2'd2; req_write = 1'b1; req_valid = 1'b1; end
                if (n == 6) req_valid = 1'b0;
                if (beat_ack !== (n == 12) && bad < 0) bad = n;
            end
            check(bad < 0, "R7", "strobe timing with intruding request", bad, -1);
            bad = 0;
            for (int n = 0; n < 4; n++) begin
                @(negedge clk);
                if (busy !== 1'b0) bad++;
            end
            check(bad == 0, "R7", "intruding request not accepted", bad, 0);
        end

        // R9: rewriting bank 0 replaces its reset options
        set_cfg(2'd0, 4'd1, 3'd0, 1'b0, 1'b0, 1'b0);
        do_access(2'd0, 1'b0, 1'b0, 1'b0, 3, 1, 1'b0, "R9");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule